// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the addresses of a four-beat burst. A load strobe captures a start address. Each advance strobe then moves the burst one beat further. The two low address bits follow one of two orders, picked by a mode input that is meant to stay static.

In linear order the low bits count upward from the start value and wrap modulo four. In interleaved order the low bits are the start value XORed with the beat number. The upper address bits are taken from the loaded address and are never changed by advances, so a burst stays inside its aligned group of four words.

A stall input freezes the whole sequencer. While stall is high, the block ignores both strobes and the address input. A memory controller uses this block next to its array to walk the words of a burst from a single address it has already registered.

Top module: `burst_seq`

## Requirements
- R1: After reset, `addr_out` is 0 and `beat` is 0.
- R2: A `load` while `stall` is low captures `addr_in`. In the following cycle `addr_out` equals that address and `beat` is 0, in either mode.
- R3: A `step` while `stall` and `load` are low increments `beat` by one modulo 4.
- R4: With `interleave` = 0, the low two bits of `addr_out` equal (start low bits + `beat`) mod 4. For example, a start of 1 gives 1,2,3,0.
- R5: With `interleave` = 1, the low two bits of `addr_out` equal start low bits XOR `beat`. For example, a start of 1 gives 1,0,3,2.
- R6: While `stall` is high, `addr_out` and `beat` keep their values, whatever `load`, `step` and `addr_in` do.
- R7: When `load` and `step` are both high with `stall` low, the load takes effect and the step is discarded.
- R8: Advances never change `addr_out[AW-1:2]`. After four steps the burst is back at its first address.
- R9: A cycle with neither strobe high leaves `addr_out` and `beat` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | High freezes all state and ignores the other inputs |
| load | input | 1 | Capture `addr_in` as a new burst start |
| step | input | 1 | Advance the burst by one beat |
| interleave | input | 1 | 1 selects interleaved order, 0 selects linear order |
| addr_in | input | AW | Burst start address |
| addr_out | output | AW | Current burst address |
| beat | output | 2 | Beat index within the burst |

## Verification
Every strobe acts at the rising edge that samples it, so `addr_out` and `beat` reflect it one register stage later. A change of `interleave` alters `addr_out` within the same cycle, because the order is applied combinationally to the registered state. The bench drives inputs at the falling edge and compares both outputs 1 ns after the next rising edge. It compares them against a model that it updates at that same edge. A stalled or idle cycle is therefore compared against the previous cycle's expectation, and the comparison happens before any new stimulus is applied.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          load,
  input  logic          step,
  input  logic          interleave,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic [1:0]    beat
);

  logic [AW-1:0] start_q;
  logic [1:0]    beat_q;
  logic [1:0]    low_lin, low_ilv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (!stall) begin
      if (load) begin
        start_q <= addr_in;
        beat_q  <= '0;
      end else if (step) begin
        beat_q  <= beat_q + 2'd1;
      end
    end
  end

  assign low_lin  = start_q[1:0] + beat_q;
  assign low_ilv  = start_q[1:0] ^ beat_q;
  assign addr_out = {start_q[AW-1:2], interleave ? low_ilv : low_lin};
  assign beat     = beat_q;

endmodule

module burst_seq_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          load,
  input logic          step,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out,
  input logic [1:0]    beat
);

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !stall) |=> (addr_out == $past(addr_in) && beat == 2'd0)); // R2

  AST_STEP_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !stall) |=> (beat == $past(beat) + 2'd1)); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(beat) && $stable(addr_out[AW-1:2]))); // R6

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && !stall) |=> $stable(addr_out[AW-1:2])); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(beat)); // R9

endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .load(load), .step(step),
  .addr_in(addr_in), .addr_out(addr_out), .beat(beat)
);

// File: tb/sim_burst_seq.sv
`timescale 1ns/1ps
module sim_burst_seq;
  localparam int AW = 17;

  logic clk = 0, rst_n = 0;
  logic stall = 0, load = 0, step = 0, interleave = 0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0] beat;

  int checks = 0, errors = 0;
  logic [AW-1:0] m_start = '0;
  logic [1:0]    m_beat = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_seq #(.AW(AW)) u0 (.*);

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] s, logic [1:0] b, logic ilv);
    logic [1:0] lo;
    lo = ilv ? (s[1:0] ^ b) : (s[1:0] + b);
    return {s[AW-1:2], lo};
  endfunction

  task automatic check(string tag);
    logic [AW-1:0] ea;
    ea = exp_addr(m_start, m_beat, interleave);
    checks++;
    if (addr_out !== ea || beat !== m_beat) begin
      errors++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, addr_out, beat, ea, m_beat);
    end
  endtask

  task automatic cyc(bit s, bit l, bit st, logic [AW-1:0] a, string tag);
    @(negedge clk);
    stall = s; load = l; step = st; addr_in = a;
    @(posedge clk);
    if (!s) begin
      if (l) begin m_start = a; m_beat = 0; end
      else if (st) m_beat = m_beat + 2'd1;
    end
    #1 check(tag);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #1 check("R1");
    #10 rst_n = 1;
    @(negedge clk) check("R1");

    interleave = 0;
    cyc(0, 1, 0, 17'h1ABC5, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, '0, "R4");
    cyc(0, 0, 0, 17'h00003, "R9");

    interleave = 1;
    cyc(0, 1, 0, 17'h0F0F1, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, '0, "R5");
    cyc(0, 0, 1, '0, "R8");

    cyc(0, 0, 1, '0, "R3");
    for (int i = 0; i < 3; i++) cyc(1, i[0], 1, 17'h15555, "R6");
    cyc(0, 1, 1, 17'h0AAAA, "R7");

    interleave = 0;
    cyc(0, 1, 0, 17'h12342, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, '0, "R8");

    for (int i = 0; i < 2000; i++) begin
      logic [AW-1:0] a;
      bit s, l, st;
      a  = AW'($urandom);
      s  = ($urandom % 5) == 0;
      l  = ($urandom % 4) == 0;
      st = ($urandom % 3) != 0;
      if ((i % 300) == 0) interleave = ~interleave;
      cyc(s, l, st, a, s ? "R6" : (l ? "R2" : (st ? "R3" : "R9")));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule